// File: doc/BRIEF.md
# Timer Channel Output Controller

This block owns the level of one timer output pin. It holds a software-writable output latch together with three control bits: an output enable, a mode select and an active-level select. While the enable is clear, the latch is under software control only, which is how the idle (default) pin level is prepared before the timer is started. Once enabled, the latch follows timer events, and these events are only honoured on cycles where the count-clock strobe is high.

In toggle mode, each event from the owning channel inverts the pin. In combination mode, the block produces PWM from two event streams. An event from the master channel drives the pin to its active level, and that set is applied a fixed number of count clocks later (one by default). An event from the slave channel returns the pin to its inactive level on the same count clock. If a set and a reset fall on the same count clock, the reset wins, so both 0% and 100% duty can be produced.

A change of the active-level bit does not move the pin by itself. It takes effect at the next set or reset. The control bits act only on the output path, so they can be rewritten while the counters run.

Top module: `tco_output_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the latch, enable, mode and active-level bits all read 0 and the pin is 0.
- R2: While the enable bit is 0, a latch write sets the pin to the written value on the next cycle, and events on either channel leave the pin unchanged.
- R3: Each of the four fields (latch, enable, mode, level) has its own write strobe. A write to some fields leaves the other fields at their previous values.
- R4: In toggle mode (mode bit 0) with the enable set, each owning-channel event on a count-clock cycle inverts the pin one cycle later. The active-level bit and slave events have no effect in this mode.
- R5: With the enable set, when a timer update and a software latch write occur in the same cycle, the timer update is what reaches the pin.
- R6: In combination mode (mode bit 1), a master event applies the active level one count clock after the event. The active level is 1 when the level bit is 0, and 0 when the level bit is 1.
- R7: In combination mode, a slave event on a count-clock cycle drives the pin to the inactive level (equal to the level bit) one cycle later.
- R8: When a delayed set and a slave reset fall on the same count clock, the reset wins and the pin goes inactive.
- R9: Rewriting the level bit while running leaves the pin unchanged until the next set or reset, which then uses the new polarity.
- R10: Events on cycles where the count-clock strobe is low cause no pin change, and a pending set waits for the next count clock.
- R11: The latch read port always equals the pin level, whether the enable is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cnt_tick_i | input | 1 | Count-clock enable strobe |
| evt_own_i | input | 1 | Event from the owning (master) channel |
| evt_slave_i | input | 1 | Event from the slave channel |
| wr_lat_en_i | input | 1 | Write strobe for the output latch |
| wr_lat_val_i | input | 1 | Value written to the output latch |
| wr_oe_en_i | input | 1 | Write strobe for the enable bit |
| wr_oe_val_i | input | 1 | Value written to the enable bit |
| wr_mode_en_i | input | 1 | Write strobe for the mode bit |
| wr_mode_val_i | input | 1 | Mode value (0 toggle, 1 combination) |
| wr_lvl_en_i | input | 1 | Write strobe for the active-level bit |
| wr_lvl_val_i | input | 1 | Level value (0 active high, 1 active low) |
| pin_o | output | 1 | Timer output pin level |
| lat_rd_o | output | 1 | Read-back of the output latch |
| oe_rd_o | output | 1 | Read-back of the enable bit |
| mode_rd_o | output | 1 | Read-back of the mode bit |
| lvl_rd_o | output | 1 | Read-back of the active-level bit |

## Verification
Register writes, toggles and slave resets show on the pin one clock after the edge that samples them. A master set shows one clock after the following count-clock edge, so with back-to-back strobes it is due two clocks after the event. All stimulus is driven on the falling edge, and each check samples one time unit after the rising edge that the result is due from. Where a delay matters, the bench also checks the cycle before it, so that an early set is caught as well as a missing one.

// File: rtl/tco_pkg.sv
// Package: shared types for the timer channel output controller.
// Assumes: single-bit output path; mode encoding is fixed by the requirements.
package tco_pkg;

    typedef enum logic {
        TCO_TOGGLE = 1'b0,
        TCO_COMBO  = 1'b1
    } tco_mode_e;

    typedef struct packed {
        logic      oe;
        tco_mode_e mode;
        logic      lvl;
    } tco_cfg_t;

endpackage

// File: rtl/tco_cfg_regs.sv
// Module: control-bit register file (enable, mode, level).
// Does: stores each field under its own write strobe.
// Assumes: synchronous active-low reset clears every field to 0.
module tco_cfg_regs
    import tco_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wr_oe_en_i,
    input  logic     wr_oe_val_i,
    input  logic     wr_mode_en_i,
    input  logic     wr_mode_val_i,
    input  logic     wr_lvl_en_i,
    input  logic     wr_lvl_val_i,
    output tco_cfg_t cfg_o
);

    tco_cfg_t cfg_q;

    // Per-field register update under independent strobes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q.oe   <= 1'b0;
            cfg_q.mode <= TCO_TOGGLE;
            cfg_q.lvl  <= 1'b0;
        end else begin
            if (wr_oe_en_i)   cfg_q.oe   <= wr_oe_val_i;
            if (wr_mode_en_i) cfg_q.mode <= tco_mode_e'(wr_mode_val_i);
            if (wr_lvl_en_i)  cfg_q.lvl  <= wr_lvl_val_i;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/tco_set_delay.sv
// Module: delays master-channel set requests by SET_DELAY count clocks.
// Does: captures master events seen in combination mode and shifts them
//       on each count-clock strobe; set_due_o marks the count clock the
//       delayed set belongs to.
// Assumes: SET_DELAY >= 1; reset clears all pending sets.
module tco_set_delay #(
    parameter int unsigned SET_DELAY = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cnt_tick_i,
    input  logic capture_i,
    output logic set_due_o
);

    localparam int unsigned LAST = SET_DELAY - 1;

    logic [LAST:0] pend_q;

    generate
        if (SET_DELAY == 1) begin : g_single
            // Single-stage pending flag, refreshed every count clock.
            always_ff @(posedge clk_i) begin
                if (!rst_ni)         pend_q <= '0;
                else if (cnt_tick_i) pend_q <= capture_i;
            end
        end else begin : g_chain
            // Multi-stage shift of pending sets, advanced every count clock.
            always_ff @(posedge clk_i) begin
                if (!rst_ni)         pend_q <= '0;
                else if (cnt_tick_i) pend_q <= {pend_q[LAST-1:0], capture_i};
            end
        end
    endgenerate

    assign set_due_o = pend_q[LAST];

endmodule

// File: rtl/tco_out_latch.sv
// Module: output latch with timer/software arbitration.
// Does: applies toggle, reset, delayed set or software write to the latch.
//       Priority: toggle / reset, then set, then software write.
// Assumes: timer actions only on count-clock cycles with the enable set.
module tco_out_latch
    import tco_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     cnt_tick_i,
    input  logic     evt_own_i,
    input  logic     evt_slave_i,
    input  logic     set_due_i,
    input  tco_cfg_t cfg_i,
    input  logic     wr_lat_en_i,
    input  logic     wr_lat_val_i,
    output logic     lat_o
);

    logic lat_q;
    logic act;
    logic do_tgl;
    logic do_rst;
    logic do_set;
    logic lat_d;

    // Decode which timer action, if any, this cycle carries.
    always_comb begin
        act    = cnt_tick_i & cfg_i.oe;
        do_tgl = act & (cfg_i.mode == TCO_TOGGLE) & evt_own_i;
        do_rst = act & (cfg_i.mode == TCO_COMBO)  & evt_slave_i;
        do_set = act & (cfg_i.mode == TCO_COMBO)  & set_due_i;
    end

    // Select next latch value by fixed priority.
    always_comb begin
        if (do_tgl)           lat_d = ~lat_q;
        else if (do_rst)      lat_d = cfg_i.lvl;
        else if (do_set)      lat_d = ~cfg_i.lvl;
        else if (wr_lat_en_i) lat_d = wr_lat_val_i;
        else                  lat_d = lat_q;
    end

    // Latch register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) lat_q <= 1'b0;
        else         lat_q <= lat_d;
    end

    assign lat_o = lat_q;

endmodule

// File: rtl/tco_output_ctrl.sv
// Module: timer channel output controller (top).
// Does: drives one timer pin from channel events in toggle or set/reset
//       (PWM) mode, with software default level and read-back.
// Assumes: single clock, count-clock strobe qualifies events,
//          synchronous active-low reset.
module tco_output_ctrl
    import tco_pkg::*;
#(
    parameter int unsigned SET_DELAY = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cnt_tick_i,
    input  logic evt_own_i,
    input  logic evt_slave_i,
    input  logic wr_lat_en_i,
    input  logic wr_lat_val_i,
    input  logic wr_oe_en_i,
    input  logic wr_oe_val_i,
    input  logic wr_mode_en_i,
    input  logic wr_mode_val_i,
    input  logic wr_lvl_en_i,
    input  logic wr_lvl_val_i,
    output logic pin_o,
    output logic lat_rd_o,
    output logic oe_rd_o,
    output logic mode_rd_o,
    output logic lvl_rd_o
);

    tco_cfg_t cfg;
    logic     set_due;
    logic     capture;
    logic     lat;

    tco_cfg_regs u_cfg (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_oe_en_i    (wr_oe_en_i),
        .wr_oe_val_i   (wr_oe_val_i),
        .wr_mode_en_i  (wr_mode_en_i),
        .wr_mode_val_i (wr_mode_val_i),
        .wr_lvl_en_i   (wr_lvl_en_i),
        .wr_lvl_val_i  (wr_lvl_val_i),
        .cfg_o         (cfg)
    );

    // Master events only start a set in combination mode.
    assign capture = evt_own_i & (cfg.mode == TCO_COMBO);

    tco_set_delay #(.SET_DELAY(SET_DELAY)) u_dly (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_tick_i (cnt_tick_i),
        .capture_i  (capture),
        .set_due_o  (set_due)
    );

    tco_out_latch u_lat (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cnt_tick_i   (cnt_tick_i),
        .evt_own_i    (evt_own_i),
        .evt_slave_i  (evt_slave_i),
        .set_due_i    (set_due),
        .cfg_i        (cfg),
        .wr_lat_en_i  (wr_lat_en_i),
        .wr_lat_val_i (wr_lat_val_i),
        .lat_o        (lat)
    );

    assign pin_o     = lat;
    assign lat_rd_o  = lat;
    assign oe_rd_o   = cfg.oe;
    assign mode_rd_o = cfg.mode;
    assign lvl_rd_o  = cfg.lvl;

endmodule

// File: rtl/tco_output_ctrl_chk.sv
// Module: property checker for tco_output_ctrl, attached by bind.
// Assumes: observes only top-level ports.
module tco_output_ctrl_chk #(
    parameter int unsigned SET_DELAY = 1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic cnt_tick_i,
    input logic evt_own_i,
    input logic evt_slave_i,
    input logic wr_lat_en_i,
    input logic oe,
    input logic mode,
    input logic lvl,
    input logic pin
);

    // R1
    reset_clears_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!pin && !oe && !mode && !lvl));

    // R2
    disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!oe && !wr_lat_en_i) |=> $stable(pin));

    // R4
    toggle_inverts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe && !mode && cnt_tick_i && evt_own_i) |=> (pin != $past(pin)));

    // R7
    slave_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe && mode && cnt_tick_i && evt_slave_i) |=> (pin == $past(lvl)));

    // R10
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_tick_i && !wr_lat_en_i) |=> $stable(pin));

    generate
        if (SET_DELAY == 1) begin : g_set1
            // R6
            master_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (oe && mode && cnt_tick_i && !evt_slave_i &&
                 $past(cnt_tick_i && evt_own_i && mode && rst_ni))
                |=> (pin == !$past(lvl)));
        end
    endgenerate

endmodule

bind tco_output_ctrl tco_output_ctrl_chk #(.SET_DELAY(SET_DELAY)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_tick_i  (cnt_tick_i),
    .evt_own_i   (evt_own_i),
    .evt_slave_i (evt_slave_i),
    .wr_lat_en_i (wr_lat_en_i),
    .oe          (oe_rd_o),
    .mode        (mode_rd_o),
    .lvl         (lvl_rd_o),
    .pin         (pin_o)
);

// File: tb/test_tco_output_ctrl.sv
// Bench: directed scenarios for tco_output_ctrl, one task per scenario.
module test_tco_output_ctrl;

    logic clk = 1'b0;
    logic rst_n;
    logic tick, own, slv;
    logic wl_en, wl_v, wo_en, wo_v, wm_en, wm_v, wv_en, wv_v;
    logic pin, lat_rd, oe_rd, mode_rd, lvl_rd;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tco_output_ctrl #(.SET_DELAY(1)) i_tco_output_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .cnt_tick_i(tick),
        .evt_own_i(own), .evt_slave_i(slv),
        .wr_lat_en_i(wl_en), .wr_lat_val_i(wl_v),
        .wr_oe_en_i(wo_en), .wr_oe_val_i(wo_v),
        .wr_mode_en_i(wm_en), .wr_mode_val_i(wm_v),
        .wr_lvl_en_i(wv_en), .wr_lvl_val_i(wv_v),
        .pin_o(pin), .lat_rd_o(lat_rd), .oe_rd_o(oe_rd),
        .mode_rd_o(mode_rd), .lvl_rd_o(lvl_rd)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive every input at the falling edge, then sample after the rising edge.
    task automatic cyc(input logic t, input logic o, input logic s,
                       input logic le, input logic lv, input logic oe_e, input logic oe_v,
                       input logic me, input logic mv, input logic ve, input logic vv);
        @(negedge clk);
        tick = t; own = o; slv = s;
        wl_en = le; wl_v = lv; wo_en = oe_e; wo_v = oe_v;
        wm_en = me; wm_v = mv; wv_en = ve; wv_v = vv;
        @(posedge clk);
        #1;
    endtask

    task automatic tick_ev(input logic t, input logic o, input logic s);
        cyc(t, o, s, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_ev(0, 0, 0);
        tick_ev(0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pin", pin, 1'b0);
        chk("R1 oe", oe_rd, 1'b0);
        chk("R1 mode", mode_rd, 1'b0);
        chk("R1 lvl", lvl_rd, 1'b0);
    endtask

    task automatic t_default_level();
        do_reset();
        cyc(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        chk("R2 write default", pin, 1'b1);
        chk("R11 readback disabled", lat_rd, 1'b1);
        tick_ev(1, 1, 0);
        chk("R2 own event ignored", pin, 1'b1);
        tick_ev(1, 0, 1);
        chk("R2 slave event ignored", pin, 1'b1);
        // enable and mode written together, latch and level untouched
        cyc(0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
        chk("R3 oe", oe_rd, 1'b1);
        chk("R3 mode", mode_rd, 1'b1);
        chk("R3 lvl kept", lvl_rd, 1'b0);
        chk("R3 latch kept", pin, 1'b1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R3 lvl only", lvl_rd, 1'b1);
        chk("R3 oe kept", oe_rd, 1'b1);
    endtask

    task automatic t_toggle();
        do_reset();
        // oe=1, toggle mode, level=1 (must be ignored)
        cyc(0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 1);
        tick_ev(1, 1, 0);
        chk("R4 first toggle", pin, 1'b1);
        chk("R11 readback enabled", lat_rd, 1'b1);
        tick_ev(1, 1, 0);
        chk("R4 second toggle", pin, 1'b0);
        tick_ev(0, 1, 0);
        chk("R10 no tick no toggle", pin, 1'b0);
        tick_ev(1, 0, 1);
        chk("R4 slave ignored", pin, 1'b0);
        // R5: write 0 while toggle from 0 happens -> timer wins -> 1
        cyc(1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 timer beats write", pin, 1'b1);
    endtask

    task automatic t_combo();
        do_reset();
        cyc(0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
        tick_ev(1, 1, 0);
        chk("R6 no set on event tick", pin, 1'b0);
        tick_ev(1, 0, 0);
        chk("R6 set one count later", pin, 1'b1);
        tick_ev(1, 0, 1);
        chk("R7 slave reset", pin, 1'b0);
        tick_ev(1, 1, 0);
        tick_ev(0, 0, 0);
        chk("R10 pending waits", pin, 1'b0);
        tick_ev(0, 0, 0);
        chk("R10 still waiting", pin, 1'b0);
        tick_ev(1, 0, 0);
        chk("R10 set on next tick", pin, 1'b1);
    endtask

    task automatic t_zero_duty();
        do_reset();
        cyc(0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
        tick_ev(1, 1, 0);
        tick_ev(1, 0, 1);
        chk("R8 reset wins", pin, 1'b0);
        tick_ev(1, 0, 0);
        chk("R8 stays inactive", pin, 1'b0);
    endtask

    task automatic t_polarity();
        do_reset();
        cyc(0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
        tick_ev(1, 1, 0);
        tick_ev(1, 0, 0);
        chk("R9 active high", pin, 1'b1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R9 level write no change", pin, 1'b1);
        tick_ev(1, 0, 0);
        chk("R9 idle tick no change", pin, 1'b1);
        tick_ev(1, 1, 0);
        tick_ev(1, 0, 0);
        chk("R9 set uses new level", pin, 1'b0);
        tick_ev(1, 0, 1);
        chk("R9 reset uses new level", pin, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        tick = 0; own = 0; slv = 0;
        wl_en = 0; wl_v = 0; wo_en = 0; wo_v = 0;
        wm_en = 0; wm_v = 0; wv_en = 0; wv_v = 0;
        t_reset();
        t_default_level();
        t_toggle();
        t_combo();
        t_zero_duty();
        t_polarity();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule